// File: doc/BRIEF.md
# Multichannel Serial Window Selector

This block picks, slot by slot, which channels of a time-division multiplexed serial frame take part in a transfer. Software programs a window through a size code and an offset, and sets a 128-bit channel-enable mask. An external frame-sync pulse starts a frame and a per-slot strobe steps through it. For every slot the block reports the channel index, whether that channel is active, and whether the slot is the last one of the frame.

The frame is `offset + window size` slots long. The active channels lie inside the window, from the offset up to the last slot. A window that would reach past the 128 mask entries is invalid: the frame still runs its full length, but no channel in it is marked active. The size and offset stay fixed while the serial port is enabled. The mask can be rewritten at any time and takes effect from a slot boundary.

Top module: `mc_window_sel`

## Requirements
- R1: Size code n (4 bits, 0 to 15) selects a window of 8*(n+1) channels, so code 0 gives 8 channels and code 15 gives 128.
- R2: The window starts at the programmed 7-bit offset. Slots with an index below the offset are never active. Offset 0 with code 15 makes all 128 channels usable.
- R3: Inside a valid window, the slot with index i is active exactly when bit i of the channel-enable mask is set. Outside the window no slot is active.
- R4: When offset plus window size exceeds 128, no slot of the frame is active, and the frame still lasts offset plus window size slots.
- R5: A frame has offset plus window size slots. `eof` is high only on the slot whose index is that length minus 1.
- R6: A cycle with `fsync` high makes the next cycle show slot 0 with `slot_vld` high. This holds mid-frame too, and `fsync` takes priority over `slot_stb` in the same cycle.
- R7: A `slot_stb` during a frame advances `chan_idx` by one. A `slot_stb` on the `eof` slot ends the frame: `slot_vld`, `chan_act` and `eof` stay low and `chan_idx` reads 0 until the next `fsync`.
- R8: A `cfg_we` write of size code and offset is ignored while `port_en` is high and accepted while it is low.
- R9: A mask write (`en_we`) is accepted at any time. It changes `chan_act` only from the next `slot_stb` or `fsync` edge. A mask write in the same cycle as a strobe first shows at the strobe after that.
- R10: Synchronous active-low reset clears the size code, offset and mask, stops the frame and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Serial port enabled; blocks configuration writes |
| cfg_we | input | 1 | Write strobe for size code and offset |
| cfg_size_code | input | 4 | Window size code, size = 8*(code+1) |
| cfg_offset | input | 7 | Window start channel |
| en_we | input | 1 | Write strobe for the channel-enable mask |
| en_data | input | 128 | New channel-enable mask, bit i for channel i |
| fsync | input | 1 | Frame-sync pulse, starts slot 0 |
| slot_stb | input | 1 | Advance to the next slot |
| slot_vld | output | 1 | A frame is in progress |
| chan_idx | output | 8 | Index of the current slot |
| chan_act | output | 1 | Current slot is an active channel |
| eof | output | 1 | Current slot is the last of the frame |

## Verification
A wrong slot counter shows at once as a wrong `chan_idx` on the slot after the fault and as an `eof` on the wrong slot. A wrong latched size or offset shows as a wrong frame length or a shifted active pattern within the first frame after it is programmed. A wrong mask or a wrongly timed mask transfer shows as a wrong `chan_act` on the slot where the new and old mask differ. The bench therefore compares every slot of every frame against a model built from the requirements.

// File: rtl/mc_window_sel.sv
module mc_window_sel #(
  parameter int NCH  = 128,
  parameter int GRAN = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        port_en,
  input  logic                        cfg_we,
  input  logic [$clog2(NCH/GRAN)-1:0] cfg_size_code,
  input  logic [$clog2(NCH)-1:0]      cfg_offset,
  input  logic                        en_we,
  input  logic [NCH-1:0]              en_data,
  input  logic                        fsync,
  input  logic                        slot_stb,
  output logic                        slot_vld,
  output logic [$clog2(2*NCH)-1:0]    chan_idx,
  output logic                        chan_act,
  output logic                        eof
);
  localparam int SZW = $clog2(NCH/GRAN);
  localparam int OFW = $clog2(NCH);
  localparam int CW  = $clog2(2*NCH);

  logic [SZW-1:0] size_code;
  logic [OFW-1:0] offset;
  logic [NCH-1:0] en_pend, en_live;
  logic [CW-1:0]  cnt;
  logic           run;

  logic [CW-1:0] win_size, frame_len;
  logic          cfg_ok, in_win, last;

  assign win_size  = CW'((32'(size_code) + 1) * GRAN);
  assign frame_len = CW'(offset) + win_size;
  assign cfg_ok    = frame_len <= CW'(NCH);
  assign in_win    = cfg_ok && cnt >= CW'(offset) && cnt < frame_len;
  assign last      = cnt == frame_len - CW'(1);

  assign slot_vld = run;
  assign chan_idx = cnt;
  assign chan_act = run && in_win && en_live[cnt[OFW-1:0]];
  assign eof      = run && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_code <= '0;
      offset    <= '0;
    end else if (cfg_we && !port_en) begin
      size_code <= cfg_size_code;
      offset    <= cfg_offset;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_pend <= '0;
      en_live <= '0;
    end else begin
      if (en_we) en_pend <= en_data;
      if (fsync || slot_stb) en_live <= en_pend;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (fsync) begin
      cnt <= '0;
      run <= 1'b1;
    end else if (slot_stb && run) begin
      if (last) begin
        cnt <= '0;
        run <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R8
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |=> $stable(size_code) && $stable(offset));

  // R6
  fsync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> slot_vld && chan_idx == '0);

  // R7
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stb && slot_vld && !eof && !fsync |=> slot_vld && chan_idx == CW'($past(chan_idx) + 1));

  // R7
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stb && eof && !fsync |=> !slot_vld && !chan_act && !eof);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> !slot_vld && !chan_act && !eof && chan_idx == '0);

  // R2
  below_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_act |-> chan_idx >= CW'(offset));
endmodule

// File: tb/test_mc_window_sel.sv
module test_mc_window_sel;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         port_en = 0;
  logic         cfg_we = 0;
  logic [3:0]   cfg_size_code = 0;
  logic [6:0]   cfg_offset = 0;
  logic         en_we = 0;
  logic [127:0] en_data = 0;
  logic         fsync = 0;
  logic         slot_stb = 0;
  logic         slot_vld;
  logic [7:0]   chan_idx;
  logic         chan_act;
  logic         eof;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int           m_off = 0;
  int           m_code = 0;
  logic [127:0] m_en = 0;

  mc_window_sel i_mc_window_sel (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .cfg_we(cfg_we),
    .cfg_size_code(cfg_size_code), .cfg_offset(cfg_offset),
    .en_we(en_we), .en_data(en_data), .fsync(fsync), .slot_stb(slot_stb),
    .slot_vld(slot_vld), .chan_idx(chan_idx), .chan_act(chan_act), .eof(eof)
  );

  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_act(int i, int off, int code, logic [127:0] en);
    int sz = 8 * (code + 1);
    if (off + sz > 128) return 0;
    if (i < off || i >= off + sz) return 0;
    return en[i];
  endfunction

  task automatic set_cfg(int code, int off);
    cfg_size_code = 4'(code); cfg_offset = 7'(off); cfg_we = 1;
    tick();
    cfg_we = 0;
    if (!port_en) begin m_code = code; m_off = off; end
  endtask

  task automatic set_en(logic [127:0] v);
    en_data = v; en_we = 1;
    tick();
    en_we = 0; m_en = v;
  endtask

  task automatic run_frame(string req);
    int len = m_off + 8 * (m_code + 1);
    fsync = 1; tick(); fsync = 0;
    for (int i = 0; i < len; i++) begin
      chk(req, "slot_vld", slot_vld, 1);
      chk(req, "chan_idx", chan_idx, i);
      chk(req, $sformatf("chan_act@%0d", i), chan_act, exp_act(i, m_off, m_code, m_en));
      chk(req, $sformatf("eof@%0d", i), eof, i == len - 1);
      slot_stb = 1; tick(); slot_stb = 0;
    end
    chk("R7", "slot_vld after frame", slot_vld, 0);
    chk("R7", "chan_idx after frame", chan_idx, 0);
    slot_stb = 1; tick(); slot_stb = 0;
    chk("R7", "slot_vld stays low", slot_vld, 0);
    chk("R7", "chan_act stays low", chan_act, 0);
    chk("R7", "eof stays low", eof, 0);
  endtask

  task automatic t_reset();
    rst_n = 0; tick(); tick(); rst_n = 1;
    chk("R10", "slot_vld", slot_vld, 0);
    chk("R10", "chan_act", chan_act, 0);
    chk("R10", "eof", eof, 0);
    chk("R10", "chan_idx", chan_idx, 0);
    m_code = 0; m_off = 0; m_en = 0;
    run_frame("R10");
  endtask

  task automatic t_basic();
    set_cfg(0, 0);
    set_en(128'hA5);
    run_frame("R1");
    set_cfg(3, 0);
    set_en({96'h0, 32'hF0F0_1234});
    run_frame("R1");
  endtask

  task automatic t_offset();
    set_cfg(0, 93);
    set_en('1);
    run_frame("R2");
    set_cfg(1, 40);
    set_en({64'h0, 64'hFFFF_0000_5555_AAAA});
    run_frame("R3");
  endtask

  task automatic t_full();
    set_cfg(15, 0);
    set_en({32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 32'hFFFF_0001});
    run_frame("R2");
    set_cfg(0, 120);
    set_en('1);
    run_frame("R5");
  endtask

  task automatic t_invalid();
    set_en('1);
    set_cfg(0, 121);
    run_frame("R4");
    set_cfg(15, 1);
    run_frame("R4");
  endtask

  task automatic t_locked();
    set_cfg(1, 4);
    set_en('1);
    port_en = 1;
    set_cfg(7, 60);
    run_frame("R8");
    port_en = 0;
    set_cfg(0, 2);
    run_frame("R8");
  endtask

  task automatic t_mask_timing();
    set_cfg(0, 0);
    set_en('0);
    fsync = 1; tick(); fsync = 0;
    chk("R9", "slot0 act before write", chan_act, 0);
    en_data = '1; en_we = 1; tick(); en_we = 0;
    chk("R9", "slot0 act after write, no strobe", chan_act, 0);
    chk("R9", "still slot0", chan_idx, 0);
    slot_stb = 1; tick(); slot_stb = 0;
    chk("R9", "slot1 act after strobe", chan_act, 1);
    en_data = '0; en_we = 1; slot_stb = 1; tick(); en_we = 0; slot_stb = 0;
    chk("R9", "slot2 act, write with strobe", chan_act, 1);
    slot_stb = 1; tick(); slot_stb = 0;
    chk("R9", "slot3 act, next strobe", chan_act, 0);
    m_en = '0;
    fsync = 1; tick(); fsync = 0;
  endtask

  task automatic t_restart();
    set_cfg(1, 0);
    set_en('1);
    fsync = 1; tick(); fsync = 0;
    for (int i = 0; i < 5; i++) begin slot_stb = 1; tick(); slot_stb = 0; end
    chk("R7", "mid-frame idx", chan_idx, 5);
    fsync = 1; slot_stb = 1; tick(); fsync = 0; slot_stb = 0;
    chk("R6", "restart idx", chan_idx, 0);
    chk("R6", "restart vld", slot_vld, 1);
    tick();
    chk("R7", "no strobe holds idx", chan_idx, 0);
    run_frame("R6");
    fsync = 1; tick(); fsync = 0;
    slot_stb = 1; tick(); slot_stb = 0;
    rst_n = 0; tick(); rst_n = 1;
    chk("R10", "reset mid-frame vld", slot_vld, 0);
    chk("R10", "reset mid-frame idx", chan_idx, 0);
    m_code = 0; m_off = 0; m_en = 0;
    run_frame("R10");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_offset();
    t_full();
    t_invalid();
    t_locked();
    t_mask_timing();
    t_restart();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule